// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block watches a running calendar time and raises an interrupt when the time matches a programmed alarm. The calendar arrives on six 7-bit BCD inputs: seconds, minutes, hours, date, month and weekday. A one-cycle advance strobe marks each cycle in which the time has just moved to a new value. The block does not keep time itself.

Software programs six alarm registers and one control register through a simple read/write register port. Each alarm register has its own enable bit, and only the enabled fields take part in the comparison. An alarm with some fields disabled therefore repeats by itself. For example, an alarm with only the seconds field enabled fires once per minute.

On a match, a sticky alarm flag is set and the active-low interrupt is driven. The control register selects one of two interrupt modes:
- In level mode, the interrupt stays low until software clears the flag.
- In pulse mode, every match gives a low pulse of fixed length, whether or not the flag has been cleared.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset every alarm register reads 0x00, the control register reads 0x00 (level mode), the status register reads 0x00 and `irq_n` is high.
- R2: Register map: address 0 is seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 weekday. These are 8-bit registers that read back exactly as written. Address 6 is control: only bit 0 is stored (0 = level mode, 1 = pulse mode), and the other bits read 0. Address 7 is status: bit 0 is the alarm flag, and the other bits read 0.
- R3: In an alarm register, bit 7 enables the field and bits 6:0 hold the BCD value compared with the matching time input. A field whose bit 7 is 0 takes no part in the match.
- R4: When all six alarm registers have bit 7 clear, no alarm ever fires.
- R5: A match is evaluated only in a cycle where `tm_tick` is high. A time value that is held with no strobe never fires.
- R6: A match in the strobe cycle sets the status flag and drives `irq_n` low from the next cycle.
- R7: In level mode, `irq_n` stays low while the flag is 1. Writing 0 to status bit 0 clears the flag, and `irq_n` is high from the next cycle. Writing 1 to status bit 0 has no effect.
- R8: In pulse mode, each match drives `irq_n` low for exactly `PULSE_CYCLES` cycles (default 4), starting the cycle after the strobe. The flag is still set, but later pulses occur without it being cleared.
- R9: When a match and a status clear fall in the same cycle, the flag ends up set.
- R10: An alarm with only the seconds field enabled fires once per minute, at each strobe where the seconds input equals the programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tm_tick | input | 1 | Time-advance strobe, one cycle per new time |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 7 | Current hours, BCD |
| tm_date | input | 7 | Current day of month, BCD |
| tm_month | input | 7 | Current month, BCD |
| tm_wday | input | 7 | Current weekday, 0 to 6 |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The hardest case to reach from the ports is a match and a status clear landing in the same clock edge. The bench reaches it by raising the strobe, with a matching seconds value, in the same cycle that it writes 0 to the status register. It then reads the flag back. Repeated pulses with the flag left set are reached by stepping a seconds-only alarm through two simulated minutes. The bench counts every low cycle of `irq_n` after each strobe.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FIELDS = 6;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 8;
  localparam int VAL_W  = 7;
  localparam int EN_BIT = REG_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd7;

  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_PULSE = 1'b1
  } irq_mode_e;

  typedef logic [FIELDS-1:0][VAL_W-1:0] time_vec_t;
  typedef logic [FIELDS-1:0][REG_W-1:0] alarm_vec_t;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              status,
  output alarm_vec_t        alarms,
  output irq_mode_e         mode,
  output logic              clr_req,
  output logic [REG_W-1:0]  rd_data
);

  // one register per calendar field
  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alarms[g] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(g)) begin
        alarms[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= IRQ_LEVEL;
    end else if (wr_en && wr_addr == ADDR_CTRL) begin
      mode <= irq_mode_e'(wr_data[0]);
    end
  end

  // a write of 0 to the flag bit requests a clear; a 1 does nothing
  assign clr_req = wr_en && (wr_addr == ADDR_STAT) && !wr_data[0];

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < FIELDS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = alarms[i];
    end
    if (rd_addr == ADDR_CTRL) rd_data = {{(REG_W-1){1'b0}}, mode};
    if (rd_addr == ADDR_STAT) rd_data = {{(REG_W-1){1'b0}}, status};
  end

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_CTRL) |=> $stable(mode));

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic       tick,
  input  time_vec_t  now,
  input  alarm_vec_t alarms,
  output logic       hit
);

  logic [FIELDS-1:0] field_en;
  logic [FIELDS-1:0] field_ok;

  for (genvar g = 0; g < FIELDS; g++) begin : g_cmp
    assign field_en[g] = alarms[g][EN_BIT];
    assign field_ok[g] = !field_en[g] || (alarms[g][VAL_W-1:0] == now[g]);
  end

  // at least one enabled field, all enabled fields equal, on a strobe only
  assign hit = tick && (|field_en) && (&field_ok);

endmodule

// File: rtl/alarm_irq.sv
module alarm_irq
  import alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode,
  input  logic      hit,
  input  logic      clr_req,
  output logic      status,
  output logic      irq_n
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] pulse_cnt;
  logic [CNT_W:0]   low_run;

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= 1'b0;
    else if (hit)     status <= 1'b1;
    else if (clr_req) status <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pulse_cnt <= '0;
    else if (hit)            pulse_cnt <= CNT_W'(PULSE_CYCLES);
    else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign irq_n = (mode == IRQ_PULSE) ? (pulse_cnt == 0) : !status;

  // checker: length of the current low run since the last match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (hit)    low_run <= '0;
    else if (!irq_n) low_run <= low_run + 1'b1;
    else             low_run <= '0;
  end

  assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status);

  assert_level_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQ_LEVEL && clr_req && !hit) |=> (irq_n || mode != IRQ_LEVEL));

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQ_PULSE && !irq_n) |-> (low_run < (CNT_W+1)'(PULSE_CYCLES)));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_req) |=> status);

endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
  import alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tm_tick,
  input  logic [VAL_W-1:0]  tm_sec,
  input  logic [VAL_W-1:0]  tm_min,
  input  logic [VAL_W-1:0]  tm_hour,
  input  logic [VAL_W-1:0]  tm_date,
  input  logic [VAL_W-1:0]  tm_month,
  input  logic [VAL_W-1:0]  tm_wday,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              irq_n
);

  time_vec_t  now;
  alarm_vec_t alarms;
  irq_mode_e  mode;
  logic       clr_req;
  logic       status;
  logic       hit;

  assign now = {tm_wday, tm_month, tm_date, tm_hour, tm_min, tm_sec};

  alarm_regfile i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .rd_addr (reg_rd_addr),
    .status  (status),
    .alarms  (alarms),
    .mode    (mode),
    .clr_req (clr_req),
    .rd_data (reg_rd_data)
  );

  alarm_match i_match (
    .tick   (tm_tick),
    .now    (now),
    .alarms (alarms),
    .hit    (hit)
  );

  alarm_irq #(.PULSE_CYCLES(PULSE_CYCLES)) i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .hit     (hit),
    .clr_req (clr_req),
    .status  (status),
    .irq_n   (irq_n)
  );

  assert_no_hit_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tm_tick |=> $stable(status) || !status);

  assert_all_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alarms[0][EN_BIT] == 1'b0 && alarms[1][EN_BIT] == 1'b0 &&
     alarms[2][EN_BIT] == 1'b0 && alarms[3][EN_BIT] == 1'b0 &&
     alarms[4][EN_BIT] == 1'b0 && alarms[5][EN_BIT] == 1'b0 && !status)
    |=> !status);

endmodule

// File: tb/test_alarm_irq_top.sv
module test_alarm_irq_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tm_tick = 1'b0;
  logic [6:0] tm_sec = '0, tm_min = '0, tm_hour = '0;
  logic [6:0] tm_date = '0, tm_month = '0, tm_wday = '0;
  logic       reg_wr_en = 1'b0;
  logic [2:0] reg_wr_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic [2:0] reg_rd_addr = '0;
  logic [7:0] reg_rd_data;
  logic       irq_n;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_top #(.PULSE_CYCLES(PULSE)) i_alarm_irq_top (
    .clk(clk), .rst_n(rst_n), .tm_tick(tm_tick),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
    .tm_date(tm_date), .tm_month(tm_month), .tm_wday(tm_wday),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .irq_n(irq_n)
  );

  function automatic logic [6:0] bcd(int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_expect(logic [2:0] a, logic [7:0] exp, string req);
    reg_rd_addr = a;
    #1;
    check(reg_rd_data == exp, req, reg_rd_data, exp);
  endtask

  task automatic set_time(int s, int m, int h, int d, int mo, int w);
    tm_sec = bcd(s); tm_min = bcd(m); tm_hour = bcd(h);
    tm_date = bcd(d); tm_month = bcd(mo); tm_wday = bcd(w);
  endtask

  // strobe a new time; returns at the negedge after the strobe edge
  task automatic tick_at(int s, int m, int h, int d, int mo, int w);
    @(negedge clk);
    set_time(s, m, h, d, mo, w);
    tm_tick = 1'b1;
    @(negedge clk);
    tm_tick = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 6; i++) wr(3'(i), 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h00);
  endtask

  task automatic t_reset();
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    for (int i = 0; i < 8; i++) rd_expect(3'(i), 8'h00, "R1 reset value");
  endtask

  task automatic t_regs();
    for (int i = 0; i < 6; i++) wr(3'(i), 8'(8'h11 * (i + 1) | 8'h80));
    for (int i = 0; i < 6; i++) rd_expect(3'(i), 8'(8'h11 * (i + 1) | 8'h80), "R2 readback");
    wr(3'd6, 8'hFF);
    rd_expect(3'd6, 8'h01, "R2 control bit0 only");
    rd_expect(3'd7, 8'h00, "R2 status idle");
    clear_all();
  endtask

  task automatic t_full_date();
    wr(3'd0, 8'h80); wr(3'd1, 8'hB0); wr(3'd2, 8'h91);
    wr(3'd3, 8'h81); wr(3'd4, 8'h81); wr(3'd5, 8'h00);
    tick_at(59, 29, 11, 1, 1, 4);
    check(irq_n == 1'b1, "R3 one second early", irq_n, 1);
    tick_at(0, 30, 11, 1, 1, 4);
    check(irq_n == 1'b0, "R6 full date match irq", irq_n, 0);
    rd_expect(3'd7, 8'h01, "R6 status set");
    repeat (3) @(negedge clk);
    check(irq_n == 1'b0, "R7 level held", irq_n, 0);
    wr(3'd7, 8'h01);
    rd_expect(3'd7, 8'h01, "R7 write 1 no effect");
    wr(3'd7, 8'h00);
    check(irq_n == 1'b1, "R7 cleared irq", irq_n, 1);
    rd_expect(3'd7, 8'h00, "R7 status cleared");
    repeat (6) @(negedge clk);
    check(irq_n == 1'b1, "R5 held time no strobe", irq_n, 1);
    rd_expect(3'd7, 8'h00, "R5 status stays 0");
  endtask

  task automatic t_weekday();
    wr(3'd5, 8'h83);
    tick_at(0, 30, 11, 1, 1, 2);
    check(irq_n == 1'b1, "R3 weekday mismatch", irq_n, 1);
    tick_at(0, 30, 11, 1, 1, 3);
    check(irq_n == 1'b0, "R3 weekday match", irq_n, 0);
    clear_all();
  endtask

  task automatic t_all_off();
    for (int k = 0; k < 5; k++) begin
      tick_at(k * 7, k, k, 0, 0, 0);
      check(irq_n == 1'b1, "R4 all disabled irq", irq_n, 1);
    end
    rd_expect(3'd7, 8'h00, "R4 all disabled status");
  endtask

  task automatic t_set_wins();
    wr(3'd0, 8'h85);
    @(negedge clk);
    tm_sec = bcd(5); tm_tick = 1'b1;
    reg_wr_en = 1'b1; reg_wr_addr = 3'd7; reg_wr_data = 8'h00;
    @(negedge clk);
    tm_tick = 1'b0; reg_wr_en = 1'b0;
    rd_expect(3'd7, 8'h01, "R9 set beats clear");
    check(irq_n == 1'b0, "R9 irq low", irq_n, 0);
    clear_all();
  endtask

  task automatic count_low(output int lows);
    lows = 0;
    for (int c = 0; c < PULSE + 4; c++) begin
      if (!irq_n) lows++;
      @(negedge clk);
    end
  endtask

  task automatic t_pulse();
    int lows;
    wr(3'd6, 8'h01);
    wr(3'd0, 8'hB0);
    tick_at(30, 0, 0, 1, 1, 0);
    count_low(lows);
    check(lows == PULSE, "R8 pulse width", lows, PULSE);
    rd_expect(3'd7, 8'h01, "R8 status set in pulse mode");
    tick_at(30, 1, 0, 1, 1, 0);
    count_low(lows);
    check(lows == PULSE, "R8 second pulse without clear", lows, PULSE);
  endtask

  task automatic t_minute();
    int fires = 0;
    for (int t = 0; t < 130; t++) begin
      tick_at(t % 60, t / 60, 0, 1, 1, 0);
      if (!irq_n) fires++;
      if ((t % 60 == 30) != !irq_n)
        check(1'b0, "R10 fire position", int'(!irq_n), int'(t % 60 == 30));
      repeat (PULSE + 1) @(negedge clk);
    end
    check(fires == 2, "R10 fires per two minutes", fires, 2);
    clear_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_full_date();
    t_weekday();
    t_all_off();
    t_set_wins();
    t_pulse();
    t_minute();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule